// File: doc/BRIEF.md
# OTP First-Block Lock Sequencer

This block runs, on its own, the register script that makes a flash device lock its first block permanently through the one-time-programmable area. It sits on the host side of a plain synchronous register port: a single-cycle write strobe with address and data, and a read strobe whose data comes back on the next cycle. A `start` pulse copies the configuration inputs into the block. The block then selects the block address with the die bit forced low and selects buffer 0. It enters OTP access, waits for the device interrupt and clears it. It sets the page, sector and buffer count, writes the lock marker into the spare area of the data buffer, programs it and waits for the interrupt again.

After the program step, the block requests a cold reset of the device for a fixed number of cycles and waits for `rst_done`. It then reads the controller status register and checks the first-block lock flag. The `busy`, `done`, `pass` and `phase` outputs report the outcome. When the run ends, `phase` stays on the step where it stopped, so a failed run also shows which step failed.

Top module: `otp_lock_seq`

## Requirements
- R1: After reset, `busy`, `done`, `pass` and `rst_req` are 0, `phase` is 0 and neither register strobe is asserted.
- R2: A run starts with three writes in this order: 0xF100 with `{1'b0, blk_addr}`, then 0xF101 with 0x0000, then 0xF220 with 0x0065.
- R3: In each wait step the block reads 0xF241 repeatedly. It continues only after a read with bit 15 = 0 is followed by a read with bit 15 = 1. An interrupt that reads 1 from the first read onward is never accepted.
- R4: After each accepted interrupt the block writes 0x0000 to 0xF241. When `auto_int` was 1 at start, both of these writes are left out.
- R5: Buffer setup writes 0x0000 to 0xF107 and then writes to 0xF200. The 0xF200 value is 0x0801 when `buf_alt` = 0 and 0x0C01 when `buf_alt` = 1.
- R6: The lock marker 0xFFF3 is written to address `MARK_ADDR` (default 0x8017), after the 0xF200 write and before the program command.
- R7: The program command written to 0xF220 is 0x0080 when `prog_alt` = 0 and 0x001A when `prog_alt` = 1.
- R8: After the second wait step, `rst_req` is high for exactly `RST_CYC` consecutive cycles (default 4). Register 0xF240 is not read until `rst_done` has been seen high after that.
- R9: The run ends with one read of 0xF240. If bit 5 is 1: `done` = 1, `pass` = 1, `phase` = 14. If bit 5 is 0: `done` = 1, `pass` = 0, `phase` = 13. `busy` falls in both cases.
- R10: If a wait step has been waiting for more than `poll_limit` cycles, the run ends with `done` = 1 and `pass` = 0. `phase` is then 4 for the wait after the OTP command and 10 for the wait after the program command, and no further register access follows.
- R11: A `start` pulse while `busy` is high has no effect. The configuration inputs (`blk_addr`, `buf_alt`, `prog_alt`, `auto_int`, `poll_limit`) are taken only when a run starts.
- R12: `reg_wr` and `reg_rd` are never high in the same cycle, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a run when the block is idle |
| blk_addr | input | 15 | Block address to place in 0xF100 |
| buf_alt | input | 1 | Selects the 0x0C01 buffer setting |
| prog_alt | input | 1 | Selects the 0x001A program command |
| auto_int | input | 1 | Device clears its interrupt itself; skip the clear writes |
| poll_limit | input | TW | Wait-step timeout in cycles |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe; data is expected next cycle |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data, valid the cycle after `reg_rd` |
| rst_req | output | 1 | Cold-reset request to the device |
| rst_done | input | 1 | Device has finished its cold reset |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run has finished; held until the next start |
| pass | output | 1 | Lock flag was found set |
| phase | output | 4 | Current step, or the step where the run stopped |

## Verification
The cases hardest to reach from the ports are the interrupt-edge rule and a timeout in the second wait step. The bench's device model raises the interrupt after a set number of reads, and it can use a different count after each command. With a count of zero, the flag reads high from the first read, so the block never sees a 0-then-1 edge and times out at phase 4. A large count used only after the program command drives the run past the first wait and into a timeout at phase 10. A second `start` pulse with changed configuration inputs, sent in the middle of a run, shows that the script already in progress stays unchanged.

// File: rtl/otp_lock_pkg.sv
package otp_lock_pkg;

  typedef enum logic [3:0] {
    PH_IDLE     = 4'd0,
    PH_BLK      = 4'd1,
    PH_DBUF     = 4'd2,
    PH_OTP_CMD  = 4'd3,
    PH_POLL_A   = 4'd4,
    PH_CLR_A    = 4'd5,
    PH_PAGE     = 4'd6,
    PH_SECT     = 4'd7,
    PH_MARK     = 4'd8,
    PH_PRG_CMD  = 4'd9,
    PH_POLL_B   = 4'd10,
    PH_CLR_B    = 4'd11,
    PH_CRST     = 4'd12,
    PH_STAT     = 4'd13,
    PH_FIN      = 4'd14
  } phase_t;

  localparam logic [15:0] A_BLK  = 16'hF100;
  localparam logic [15:0] A_DBUF = 16'hF101;
  localparam logic [15:0] A_PAGE = 16'hF107;
  localparam logic [15:0] A_SECT = 16'hF200;
  localparam logic [15:0] A_CMD  = 16'hF220;
  localparam logic [15:0] A_STAT = 16'hF240;
  localparam logic [15:0] A_INT  = 16'hF241;

  localparam logic [15:0] C_OTP     = 16'h0065;
  localparam logic [15:0] INT_MASK  = 16'h8000;
  localparam logic [15:0] LOCK_MASK = 16'h0020;

  function automatic logic [15:0] blk_word(input logic [14:0] b);
    return {1'b0, b};
  endfunction

  function automatic logic [15:0] sect_word(input logic alt);
    return alt ? 16'h0C01 : 16'h0801;
  endfunction

  function automatic logic [15:0] prog_word(input logic alt);
    return alt ? 16'h001A : 16'h0080;
  endfunction

  function automatic logic [15:0] marker_word();
    return {8'hFF, 8'hF3};
  endfunction

  function automatic logic int_set(input logic [15:0] w);
    return |(w & INT_MASK);
  endfunction

  function automatic logic lock_set(input logic [15:0] w);
    return |(w & LOCK_MASK);
  endfunction

  function automatic phase_t step_after(input phase_t p);
    return phase_t'(4'(p) + 4'd1);
  endfunction

endpackage

// File: rtl/otp_lock_script.sv
module otp_lock_script
  import otp_lock_pkg::*;
#(
  parameter logic [15:0] MARK_ADDR = 16'h8017
) (
  input  phase_t      ph,
  input  logic [14:0] blk,
  input  logic        buf_alt,
  input  logic        prog_alt,
  output logic        is_wr,
  output logic        is_rd,
  output logic [15:0] addr,
  output logic [15:0] wdata
);

  always_comb begin
    is_wr = 1'b1;
    is_rd = 1'b0;
    addr  = '0;
    wdata = '0;
    unique case (ph)
      PH_BLK:     begin addr = A_BLK;     wdata = blk_word(blk);      end
      PH_DBUF:    begin addr = A_DBUF;    wdata = '0;                 end
      PH_OTP_CMD: begin addr = A_CMD;     wdata = C_OTP;              end
      PH_CLR_A,
      PH_CLR_B:   begin addr = A_INT;     wdata = '0;                 end
      PH_PAGE:    begin addr = A_PAGE;    wdata = '0;                 end
      PH_SECT:    begin addr = A_SECT;    wdata = sect_word(buf_alt); end
      PH_MARK:    begin addr = MARK_ADDR; wdata = marker_word();      end
      PH_PRG_CMD: begin addr = A_CMD;     wdata = prog_word(prog_alt); end
      PH_POLL_A,
      PH_POLL_B:  begin is_wr = 1'b0; is_rd = 1'b1; addr = A_INT;  end
      PH_STAT:    begin is_wr = 1'b0; is_rd = 1'b1; addr = A_STAT; end
      default:    begin is_wr = 1'b0; end
    endcase
  end

endmodule

// File: rtl/otp_poll_unit.sv
module otp_poll_unit
  import otp_lock_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          sample,
  input  logic [15:0]   rdata,
  input  logic [TW-1:0] lim,
  output logic          hit,
  output logic          expire
);

  logic          seen_low;
  logic [TW-1:0] cnt;
  logic          flag;

  assign flag   = int_set(rdata);
  assign hit    = active && sample && flag && seen_low;
  assign expire = active && !hit && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_low <= 1'b0;
      cnt      <= '0;
    end else if (!active) begin
      seen_low <= 1'b0;
      cnt      <= '0;
    end else begin
      if (sample && !flag) seen_low <= 1'b1;
      if (cnt != '1) cnt <= cnt + 1'b1;
    end
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt <= lim) else $error("wait timer passed limit"); // R10
  AST_EDGE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(active)) else $error("accept without prior read"); // R3

endmodule

// File: rtl/otp_lock_seq.sv
module otp_lock_seq
  import otp_lock_pkg::*;
#(
  parameter int          TW        = 16,
  parameter int          RST_CYC   = 4,
  parameter logic [15:0] MARK_ADDR = 16'h8017
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [14:0]   blk_addr,
  input  logic          buf_alt,
  input  logic          prog_alt,
  input  logic          auto_int,
  input  logic [TW-1:0] poll_limit,
  output logic          reg_wr,
  output logic          reg_rd,
  output logic [15:0]   reg_addr,
  output logic [15:0]   reg_wdata,
  input  logic [15:0]   reg_rdata,
  output logic          rst_req,
  input  logic          rst_done,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [3:0]    phase
);

  localparam int RCW = $clog2(RST_CYC + 1);

  phase_t          st;
  logic            rd_wait;
  logic [RCW-1:0]  tmr;
  logic [14:0]     c_blk;
  logic            c_buf, c_prog, c_auto;
  logic [TW-1:0]   c_lim;

  logic            s_wr, s_rd;
  logic            poll_act, poll_hit, poll_exp;
  logic            hold_end;

  otp_lock_script #(.MARK_ADDR(MARK_ADDR)) u_script (
    .ph(st), .blk(c_blk), .buf_alt(c_buf), .prog_alt(c_prog),
    .is_wr(s_wr), .is_rd(s_rd), .addr(reg_addr), .wdata(reg_wdata)
  );

  assign poll_act = busy && (st == PH_POLL_A || st == PH_POLL_B);

  otp_poll_unit #(.TW(TW)) u_poll (
    .clk(clk), .rst_n(rst_n), .active(poll_act), .sample(rd_wait),
    .rdata(reg_rdata), .lim(c_lim), .hit(poll_hit), .expire(poll_exp)
  );

  assign reg_wr   = busy && s_wr;
  assign reg_rd   = busy && s_rd && !rd_wait;
  assign hold_end = (tmr == RCW'(RST_CYC));
  assign rst_req  = busy && (st == PH_CRST) && !hold_end;
  assign phase    = 4'(st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= PH_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      pass    <= 1'b0;
      rd_wait <= 1'b0;
      tmr     <= '0;
      c_blk   <= '0;
      c_buf   <= 1'b0;
      c_prog  <= 1'b0;
      c_auto  <= 1'b0;
      c_lim   <= '0;
    end else if (!busy) begin
      if (start) begin
        st      <= PH_BLK;
        busy    <= 1'b1;
        done    <= 1'b0;
        pass    <= 1'b0;
        rd_wait <= 1'b0;
        tmr     <= '0;
        c_blk   <= blk_addr;
        c_buf   <= buf_alt;
        c_prog  <= prog_alt;
        c_auto  <= auto_int;
        c_lim   <= poll_limit;
      end
    end else begin
      if (st != PH_CRST) tmr <= '0;
      unique case (st)
        PH_POLL_A, PH_POLL_B: begin
          rd_wait <= ~rd_wait;
          if (poll_hit) begin
            rd_wait <= 1'b0;
            if (c_auto) st <= (st == PH_POLL_A) ? PH_PAGE : PH_CRST;
            else        st <= step_after(st);
          end else if (poll_exp) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
        PH_CRST: begin
          if (!hold_end) tmr <= tmr + 1'b1;
          else if (rst_done) begin
            st      <= PH_STAT;
            rd_wait <= 1'b0;
          end
        end
        PH_STAT: begin
          rd_wait <= ~rd_wait;
          if (rd_wait) begin
            busy <= 1'b0;
            done <= 1'b1;
            pass <= lock_set(reg_rdata);
            if (lock_set(reg_rdata)) st <= PH_FIN;
          end
        end
        PH_IDLE, PH_FIN: st <= st;
        default: st <= step_after(st);
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd)) else $error("read and write together"); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(reg_wr || reg_rd || rst_req)) else $error("access while idle"); // R12
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy) else $error("done during run"); // R9
  AST_PASS_END: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (done && phase == 4'd14)) else $error("pass outside success end"); // R9
  AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !poll_exp && !(st == PH_STAT && rd_wait)) |=> busy)
    else $error("restart during run"); // R11
  AST_STAT_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_STAT && !$past(st == PH_STAT)) |-> $past(rst_done))
    else $error("status read before reset done"); // R8

endmodule

// File: tb/tb_otp_lock_seq.sv
module tb_otp_lock_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;
  localparam int RST_CYC = 4;
  localparam logic [15:0] MARK_ADDR = 16'h8017;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [14:0] blk_addr = '0;
  logic buf_alt = 1'b0, prog_alt = 1'b0, auto_int = 1'b0;
  logic [TW-1:0] poll_limit = 16'd200;
  logic reg_wr, reg_rd, rst_req, busy, done, pass;
  logic [15:0] reg_addr, reg_wdata;
  logic [15:0] reg_rdata = '0;
  logic rst_done = 1'b0;
  logic [3:0] phase;

  otp_lock_seq #(.TW(TW), .RST_CYC(RST_CYC), .MARK_ADDR(MARK_ADDR)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_addr(blk_addr),
    .buf_alt(buf_alt), .prog_alt(prog_alt), .auto_int(auto_int),
    .poll_limit(poll_limit), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rst_req(rst_req), .rst_done(rst_done), .busy(busy), .done(done),
    .pass(pass), .phase(phase)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;

  // device model state
  logic [15:0] log_a [32];
  logic [15:0] log_d [32];
  logic [15:0] exp_a [32];
  logic [15:0] exp_d [32];
  int nlog, nexp, ncmd, int_reads, d_a, d_b, rst_hi, rst_low_after, nstat;
  logic rst_seen, early_stat;
  logic [15:0] stat_val;

  always @(negedge clk) begin
    if (reg_wr && nlog < 32) begin
      log_a[nlog] = reg_addr;
      log_d[nlog] = reg_wdata;
      nlog = nlog + 1;
      if (reg_addr == 16'hF220) begin ncmd = ncmd + 1; int_reads = 0; end
    end
    if (reg_rd) begin
      if (reg_addr == 16'hF241) begin
        reg_rdata <= (int_reads >= ((ncmd <= 1) ? d_a : d_b)) ? 16'h8004 : 16'h0104;
        int_reads = int_reads + 1;
      end else if (reg_addr == 16'hF240) begin
        nstat = nstat + 1;
        if (!rst_done) early_stat = 1'b1;
        reg_rdata <= stat_val;
      end
    end
    if (rst_req) begin
      rst_hi = rst_hi + 1;
      rst_seen = 1'b1;
      rst_low_after = 0;
      rst_done <= 1'b0;
    end else if (rst_seen) begin
      rst_low_after = rst_low_after + 1;
      if (rst_low_after >= 3) rst_done <= 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected under 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic [15:0] d);
    exp_a[nexp] = a; exp_d[nexp] = d; nexp = nexp + 1;
  endtask

  // expected write script computed from R2, R4, R5, R6, R7
  task automatic build(input logic [14:0] b, input logic ba, input logic pa,
                       input logic au, input int upto);
    nexp = 0;
    push(16'hF100, {1'b0, b}); push(16'hF101, 16'h0000); push(16'hF220, 16'h0065);
    if (upto == 0) return;
    if (!au) push(16'hF241, 16'h0000);
    push(16'hF107, 16'h0000);
    push(16'hF200, ba ? 16'h0C01 : 16'h0801);
    push(MARK_ADDR, 16'hFFF3);
    push(16'hF220, pa ? 16'h001A : 16'h0080);
    if (upto == 1) return;
    if (!au) push(16'hF241, 16'h0000);
  endtask

  task automatic compare_log(input string tag);
    int bad_i;
    bad_i = -1;
    check(nlog == nexp, {tag, " write count"}, nlog, nexp);
    for (int i = 0; i < nexp && i < nlog; i++)
      if (bad_i < 0 && (log_a[i] != exp_a[i] || log_d[i] != exp_d[i])) bad_i = i;
    if (bad_i >= 0)
      check(1'b0, {tag, " write script"}, {log_a[bad_i], log_d[bad_i]},
            {exp_a[bad_i], exp_d[bad_i]});
    else check(1'b1, tag, 0, 0);
  endtask

  task automatic run(input logic [14:0] b, input logic ba, input logic pa, input logic au,
                     input int da, input int db, input int lim, input logic [15:0] sv,
                     input logic poke);
    @(posedge clk); #1;
    nlog = 0; ncmd = 0; int_reads = 0; rst_hi = 0; rst_low_after = 0; nstat = 0;
    rst_seen = 1'b0; early_stat = 1'b0; rst_done = 1'b0;
    d_a = da; d_b = db; stat_val = sv;
    @(negedge clk);
    blk_addr = b; buf_alt = ba; prog_alt = pa; auto_int = au; poll_limit = 16'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R11 busy after start", busy, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      blk_addr = ~b; buf_alt = ~ba; prog_alt = ~pa; auto_int = ~au; poll_limit = 16'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 3000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    check(done && !busy, "R9 run finished", {done, busy}, 2'b10);
  endtask

  task automatic t_reset();
    check(!busy && !done && !pass && phase == 4'd0, "R1 reset state",
          {busy, done, pass, phase}, 0);
    check(!reg_wr && !reg_rd && !rst_req, "R1 no strobes in reset",
          {reg_wr, reg_rd, rst_req}, 0);
  endtask

  task automatic t_basic();
    run(15'h7ABC, 1'b0, 1'b0, 1'b0, 2, 3, 200, 16'h0020, 1'b0);
    build(15'h7ABC, 1'b0, 1'b0, 1'b0, 2);
    compare_log("R2 R3 R4 R5 R6 R7 basic");
    check(pass == 1'b1 && phase == 4'd14, "R9 lock seen", {pass, phase}, {1'b1, 4'd14});
    check(rst_hi == RST_CYC, "R8 reset hold length", rst_hi, RST_CYC);
    check(!early_stat && nstat == 1, "R8 status after reset done", {early_stat, 8'(nstat)}, 1);
  endtask

  task automatic t_alt();
    run(15'h0001, 1'b1, 1'b1, 1'b1, 1, 1, 200, 16'hFFFF, 1'b0);
    build(15'h0001, 1'b1, 1'b1, 1'b1, 2);
    compare_log("R4 R5 R7 alternate auto");
    check(pass == 1'b1 && phase == 4'd14, "R9 alt pass", {pass, phase}, {1'b1, 4'd14});
  endtask

  task automatic t_statfail();
    run(15'h0100, 1'b0, 1'b1, 1'b0, 1, 4, 200, 16'hFFDF, 1'b0);
    check(pass == 1'b0 && phase == 4'd13, "R9 lock bit clear", {pass, phase}, {1'b0, 4'd13});
    check(rst_hi == RST_CYC, "R8 hold length second run", rst_hi, RST_CYC);
  endtask

  task automatic t_stuck();
    run(15'h0042, 1'b0, 1'b0, 1'b0, 0, 0, 30, 16'h0020, 1'b0);
    build(15'h0042, 1'b0, 1'b0, 1'b0, 0);
    compare_log("R3 R10 stuck flag stops after OTP command");
    check(pass == 1'b0 && phase == 4'd4, "R3 R10 no edge gives timeout", {pass, phase}, 4);
    repeat (5) @(negedge clk);
    check(!reg_wr && !reg_rd && nlog == 3, "R10 silent after timeout", nlog, 3);
  endtask

  task automatic t_timeout_b();
    run(15'h1234, 1'b1, 1'b0, 1'b0, 2, 1000, 40, 16'h0020, 1'b0);
    build(15'h1234, 1'b1, 1'b0, 1'b0, 1);
    compare_log("R10 second wait script");
    check(pass == 1'b0 && phase == 4'd10, "R10 timeout in second wait", {pass, phase}, 10);
    check(rst_hi == 0, "R10 no reset after timeout", rst_hi, 0);
  endtask

  task automatic t_busy_ignore();
    run(15'h2222, 1'b0, 1'b0, 1'b0, 3, 2, 200, 16'h0020, 1'b1);
    build(15'h2222, 1'b0, 1'b0, 1'b0, 2);
    compare_log("R11 restart ignored, config kept");
    check(pass == 1'b1 && phase == 4'd14, "R11 run unaffected", {pass, phase}, {1'b1, 4'd14});
  endtask

  initial begin
    nlog = 0; nexp = 0; ncmd = 0; int_reads = 0; d_a = 2; d_b = 2;
    rst_hi = 0; rst_low_after = 0; nstat = 0; rst_seen = 1'b0; early_stat = 1'b0;
    stat_val = 16'h0000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_alt();
    t_statfail();
    t_stuck();
    t_timeout_b();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule